// File: doc/BRIEF.md
# Transmit Output Path Controller

This block decides what feeds the transmit analog output of a narrowband modem front end. It also switches the transmit low-pass filter's power. Two enables are sampled on every clock: a filter enable and a modulator enable. From them the block produces a 2-bit source code for the analog output switch and a power-down level for the filter.

With the filter on, the switch picks the modulator or the voice input, and both reach the output through the filter. With the filter off, the switch picks the receive band-pass loop-back or the quiet mid-rail level, and the filter is powered down. The output buffer stays active in every case.

When the filter is switched on, it needs time to settle. For this reason, each rising edge of the filter enable opens a mute window of a whole number of milliseconds. The window is timed by a prescaler whose divide ratio depends on which master clock frequency is selected. The output stays at the quiet level until the window ends.

Top module: `tx_out_ctrl`

## Requirements
- R1: During reset and on the first cycle after it, `out_src` is 0 (quiet) and `filt_pdn` is 1.
- R2: Outputs follow the inputs sampled at the previous rising clock edge. With `tx_filt_on`=1, `mod_on`=1 and no mute active, `out_src` is 1 (modulator through filter).
- R3: With `tx_filt_on`=1, `mod_on`=0 and no mute active, `out_src` is 2 (voice through filter).
- R4: With `tx_filt_on`=0 and `mod_on`=1, `out_src` is 3 (receive filter loop-back).
- R5: With `tx_filt_on`=0 and `mod_on`=0, `out_src` is 0 (quiet).
- R6: A 0-to-1 change of `tx_filt_on` forces `out_src` to 0 for exactly DIV×MUTE_MS cycles. Those cycles start with the cycle in which the new enable first shows at the outputs. DIV is FAST_DIV when `mclk_fast`=1 at that edge and SLOW_DIV otherwise.
- R7: If `tx_filt_on` drops during a mute window, the window ends at once. On the next cycle `filt_pdn` is 1 and `out_src` follows R4/R5.
- R8: While the filter is on and no mute is active, a change of `mod_on` switches `out_src` between 1 and 2 on the next cycle, with no mute.
- R9: Changes of `mod_on` or `mclk_fast` inside a mute window neither extend it nor restart it.
- R10: `filt_pdn` is the inverse of `tx_filt_on` delayed by one cycle, and it is 0 during a mute window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_filt_on | input | 1 | Transmit filter enable |
| mod_on | input | 1 | Modulator enable |
| mclk_fast | input | 1 | 1: fast master clock (FAST_DIV per ms), 0: slow (SLOW_DIV per ms) |
| out_src | output | 2 | Output source: 0 quiet, 1 modulator, 2 voice, 3 receive loop-back |
| filt_pdn | output | 1 | Transmit filter power-down, active high |

## Verification
The bench measures the length of the mute window for both clock speeds. A prescaler that is off by one, or a divider that tracks the live speed input, changes the count of quiet cycles. It toggles the modulator enable and the speed select in the middle of a window: a design that restarts the window on these would stay quiet for too long. It drops the filter enable during a window: a design that ignores this would keep the filter powered, or report the modulator path, when the loop-back is expected. A behavioural model running in parallel catches any cycle in which the source code or the power-down differs.

// File: rtl/tx_out_ctrl.sv
module tx_out_ctrl #(
  parameter int FAST_DIV = 7372,
  parameter int SLOW_DIV = 3686,
  parameter int MUTE_MS  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_filt_on,
  input  logic       mod_on,
  input  logic       mclk_fast,
  output logic [1:0] out_src,
  output logic       filt_pdn
);
  localparam int MAXDIV = (FAST_DIV > SLOW_DIV) ? FAST_DIV : SLOW_DIV;
  localparam int DW = $clog2(MAXDIV + 1);
  localparam int MW = $clog2(MUTE_MS + 1);

  logic          filt_q, mod_q, mute;
  logic [DW-1:0] div_lim, div_cnt;
  logic [MW-1:0] ms_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      filt_q  <= 1'b0;
      mod_q   <= 1'b0;
      mute    <= 1'b0;
      div_lim <= DW'(SLOW_DIV);
      div_cnt <= '0;
      ms_cnt  <= '0;
    end else begin
      filt_q <= tx_filt_on;
      mod_q  <= mod_on;
      if (!tx_filt_on) begin
        mute    <= 1'b0;
        div_cnt <= '0;
        ms_cnt  <= '0;
      end else if (!filt_q) begin
        mute    <= 1'b1;
        div_cnt <= '0;
        ms_cnt  <= '0;
        div_lim <= mclk_fast ? DW'(FAST_DIV) : DW'(SLOW_DIV);
      end else if (mute) begin
        if (div_cnt == div_lim - 1'b1) begin
          div_cnt <= '0;
          if (ms_cnt == MW'(MUTE_MS - 1)) mute <= 1'b0;
          else ms_cnt <= ms_cnt + 1'b1;
        end else begin
          div_cnt <= div_cnt + 1'b1;
        end
      end
    end
  end

  assign filt_pdn = ~filt_q;
  assign out_src  = !filt_q ? (mod_q ? 2'd3 : 2'd0)
                  : mute    ? 2'd0
                  : (mod_q ? 2'd1 : 2'd2);

  p_loopback_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_filt_on && mod_on) |=> (out_src == 2'd3));
  p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_filt_on && !mod_on) |=> (out_src == 2'd0));
  p_rise_mute_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_filt_on && filt_pdn) |=> (out_src == 2'd0 && !filt_pdn));
  p_div_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (div_cnt < div_lim));
  p_cancel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_filt_on |=> filt_pdn);
  p_path_power_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_src == 2'd1 || out_src == 2'd2) |-> !filt_pdn);
endmodule

// File: tb/test_tx_out_ctrl.sv
module test_tx_out_ctrl;
  localparam int CLK = 10;
  localparam int Q = CLK / 4;
  localparam int FD = 12, SD = 5, MS = 3;

  logic clk = 0, rst_n = 0, f_in = 0, m_in = 0, fast_in = 0;
  logic [1:0] out_src;
  logic filt_pdn;
  int checks = 0, fails = 0;

  tx_out_ctrl #(.FAST_DIV(FD), .SLOW_DIV(SD), .MUTE_MS(MS)) i_tx_out_ctrl (
    .clk(clk), .rst_n(rst_n), .tx_filt_on(f_in), .mod_on(m_in),
    .mclk_fast(fast_in), .out_src(out_src), .filt_pdn(filt_pdn));

  always #(CLK/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit rf = 0, rm = 0;
  int left = 0;
  always @(posedge clk) begin
    if (!rst_n) begin rf = 0; rm = 0; left = 0; end
    else begin
      if (!f_in) left = 0;
      else if (!rf) left = (fast_in ? FD : SD) * MS;
      else if (left > 0) left--;
      rf = f_in; rm = m_in;
    end
    #(Q);
    if (rst_n) begin
      int e;
      string t;
      e = !rf ? (rm ? 3 : 0) : (left > 0 ? 0 : (rm ? 1 : 2));
      t = (e == 1) ? "R2" : (e == 2) ? "R3" : (e == 3) ? "R4" : rf ? "R6" : "R5";
      check(out_src == 2'(e), t, out_src, e);
      check(filt_pdn == !rf, "R10", filt_pdn, !rf);
    end
  end

  task automatic drive(input bit f, input bit m, input bit fs);
    @(negedge clk); f_in = f; m_in = m; fast_in = fs;
  endtask

  task automatic count_mute(input int chg_at, input bit m2, input bit fs2, output int n);
    n = 0;
    forever begin
      @(posedge clk); #(Q);
      if (out_src != 2'd0) break;
      n++;
      if (n == chg_at) begin @(negedge clk); m_in = m2; fast_in = fs2; end
      if (n > 1000) break;
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK * 200000);
    fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #(Q);
    check(out_src == 2'd0 && filt_pdn, "R1 reset", {out_src, filt_pdn}, 1);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #(Q);
    check(out_src == 2'd0 && filt_pdn, "R1 after", {out_src, filt_pdn}, 1);

    drive(0, 1, 0); repeat (3) @(posedge clk); #(Q);
    check(out_src == 2'd3 && filt_pdn, "R4 loopback", out_src, 3);

    drive(1, 1, 1); count_mute(0, 0, 0, n);
    check(n == FD * MS, "R6 fast window", n, FD * MS);
    check(out_src == 2'd1, "R2 modulator", out_src, 1);

    drive(1, 0, 1); @(posedge clk); #(Q);
    check(out_src == 2'd2, "R8 to voice", out_src, 2);
    check(out_src == 2'd2 && !filt_pdn, "R3 voice", out_src, 2);
    drive(1, 1, 1); @(posedge clk); #(Q);
    check(out_src == 2'd1, "R8 to modulator", out_src, 1);

    drive(0, 0, 0); @(posedge clk); #(Q);
    check(out_src == 2'd0 && filt_pdn, "R5 quiet", out_src, 0);

    drive(1, 0, 0); count_mute(0, 0, 0, n);
    check(n == SD * MS, "R6 slow window", n, SD * MS);
    check(out_src == 2'd2, "R3 after mute", out_src, 2);

    drive(0, 0, 0); repeat (2) @(posedge clk);
    drive(1, 0, 0); count_mute(5, 1, 1, n);
    check(n == SD * MS, "R9 window not extended", n, SD * MS);
    check(out_src == 2'd1, "R9 new mod value", out_src, 1);

    drive(0, 0, 1); repeat (2) @(posedge clk);
    drive(1, 1, 1); repeat (4) @(posedge clk);
    #(Q);
    check(out_src == 2'd0 && !filt_pdn, "R6 in window", out_src, 0);
    drive(0, 1, 1); @(posedge clk); #(Q);
    check(out_src == 2'd3 && filt_pdn, "R7 cancel", {out_src, filt_pdn}, 7);
    drive(1, 1, 1); count_mute(0, 0, 0, n);
    check(n == FD * MS, "R7 fresh window", n, FD * MS);

    repeat (3) @(posedge clk);
    finish_up();
  end
endmodule